// File: doc/BRIEF.md
# Byte-Loaded Frequency Word Interface

This block gives an oscillator core its 32-bit phase increment. Software, or an upstream stage, writes the word one byte at a time over an 8-bit bus into four staging bytes. A separate load strobe then commits all four bytes to the active increment in a single clock, so the oscillator never runs on a half-written word. The write strobe is active low, and the block acts on its falling edge. The load strobe acts on its rising edge. Both strobes are asynchronous to the system clock, so each one passes through a two-flop synchronizer and an edge detector before it has any effect. The address and data lines must stay steady until the synchronized falling edge of the write strobe has been captured.

A fixed number of cycles after a commit, the oscillator's pipeline has carried the new frequency to its output. At that moment the block drops its normally-high sync output for one clock. In a cascade of two stages, the lower stage's sync output drives the upper stage's load strobe, so that both stages change frequency on the same cycle. Reset is synchronous. It restarts the sync countdown but keeps the staged and active words.

Top module: `freq_word_loader`

## Requirements
- R1: The byte lane is selected by `addr` = {A1,A0}. The lanes map as follows: 2'b11 → bits 7:0, 2'b10 → bits 15:8, 2'b01 → bits 23:16, 2'b00 → bits 31:24. After all four lanes are written and committed, `inc_word` holds the assembled word.
- R2: A byte is staged on a falling edge of `wr_n`. Bit 0 of `din` lands in the least significant bit of the selected lane, and the other three lanes keep their staged values.
- R3: A commit copies all four staged bytes into `inc_word` together. `inc_word` shows the new word after the third rising clock edge that follows the rise of `ld`.
- R4: Staging writes without a load leave `inc_word` unchanged.
- R5: `sync_n` is high except for exactly one cycle. That cycle follows the 34th rising edge, counting the commit edge as the first, which makes it the 36th edge after `ld` rises.
- R6: `sync_n` is high while `rst` is high. After release, `sync_n` is low for exactly the one cycle that follows the 35th rising edge on which `rst` is sampled low.
- R7: Reset clears neither the staged bytes nor `inc_word`.
- R8: A load that arrives while a countdown is running commits the newest word and restarts the countdown. Only one sync pulse appears, and it is timed from the later commit.
- R9: A level held high on `ld` commits only once. Falling edges of `ld` and rising edges of `wr_n` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Asynchronous byte write strobe, active low |
| addr | input | 2 | Byte lane select, {A1,A0} |
| din | input | 8 | Byte data bus |
| ld | input | 1 | Asynchronous load strobe, rising edge commits |
| inc_word | output | 32 | Active phase increment |
| sync_n | output | 1 | One-cycle low marker when the new frequency reaches the output |

## Verification
The bench reverses the lane order, and a design that reversed it the same way would assemble 0x78563412 in place of 0x12345678. It writes 0x01 to the low lane to expose a bit-order swap. It leaves a write uncommitted, and a design that passed staged bytes straight through would show them on `inc_word`. It reloads in the middle of a countdown, where a design without the restart would pulse twice or pulse early. It also resets with a word loaded, and a design that cleared the registers would drop the word. A clock-by-clock model exposes an off-by-one in the 34-edge and 35-edge delays. It also exposes a held load strobe that recommits the word.

// File: rtl/freq_word_loader.sv
module freq_word_loader #(
  parameter int DATA_W        = 8,
  parameter int NUM_BYTES     = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int LOAD_LATENCY  = 34,
  parameter int RESET_LATENCY = 35,
  localparam int WORD_W = DATA_W * NUM_BYTES,
  localparam int AW     = $clog2(NUM_BYTES),
  localparam int CW     = $clog2(RESET_LATENCY + LOAD_LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ld,
  output logic [WORD_W-1:0] inc_word,
  output logic              sync_n
);

  logic [SYNC_STAGES:0] wr_sh, ld_sh;
  logic                 wr_fall, ld_rise;
  logic [AW-1:0]        lane;
  logic [DATA_W-1:0]    stage [NUM_BYTES];
  logic [CW-1:0]        cnt;
  logic                 busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sh <= '1;
      ld_sh <= '0;
    end else begin
      wr_sh <= {wr_sh[SYNC_STAGES-1:0], wr_n};
      ld_sh <= {ld_sh[SYNC_STAGES-1:0], ld};
    end
  end

  assign wr_fall = wr_sh[SYNC_STAGES] & ~wr_sh[SYNC_STAGES-1];
  assign ld_rise = ld_sh[SYNC_STAGES-1] & ~ld_sh[SYNC_STAGES];
  assign lane    = AW'(NUM_BYTES - 1) - addr;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst && wr_fall && lane == AW'(b))
        stage[b] <= din;
    end
    always_ff @(posedge clk) begin
      if (!rst && ld_rise)
        inc_word[b*DATA_W +: DATA_W] <= stage[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b1;
      cnt    <= CW'(RESET_LATENCY);
      sync_n <= 1'b1;
    end else begin
      sync_n <= ~(busy && cnt == CW'(1) && !ld_rise);
      if (ld_rise) begin
        busy <= 1'b1;
        cnt  <= CW'(LOAD_LATENCY - 1);
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/freq_word_loader_chk.sv
module freq_word_loader_chk #(
  parameter int WORD_W        = 32,
  parameter int LOAD_LATENCY  = 34,
  parameter int RESET_LATENCY = 35
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_rise,
  input logic [WORD_W-1:0] inc_word,
  input logic              sync_n
);

  logic [15:0] since;
  logic        from_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      since    <= '0;
      from_rst <= 1'b1;
    end else if (ld_rise) begin
      since    <= 16'd1;
      from_rst <= 1'b0;
    end else if (since != 16'hFFFF) begin
      since <= since + 16'd1;
    end
  end

  p_sync_single_r5: assert property (@(posedge clk) disable iff (rst)
    !sync_n |=> sync_n);

  p_sync_due_load_r5: assert property (@(posedge clk) disable iff (rst)
    (!from_rst && since == 16'(LOAD_LATENCY)) |-> !sync_n);

  p_sync_due_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (from_rst && since == 16'(RESET_LATENCY)) |-> !sync_n);

  p_sync_only_when_due_r8: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> (since == (from_rst ? 16'(RESET_LATENCY) : 16'(LOAD_LATENCY))));

  p_word_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ld_rise |=> $stable(inc_word));

endmodule

bind freq_word_loader freq_word_loader_chk #(
  .WORD_W(WORD_W), .LOAD_LATENCY(LOAD_LATENCY), .RESET_LATENCY(RESET_LATENCY)
) u_chk (
  .clk(clk), .rst(rst), .ld_rise(ld_rise), .inc_word(inc_word), .sync_n(sync_n)
);

// File: tb/sim_freq_word_loader.sv
`timescale 1ns/1ps
module sim_freq_word_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  din = 8'h00;
  logic        ld = 1'b0;
  logic [31:0] inc_word;
  logic        sync_n;

  freq_word_loader u0 (.clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr), .din(din),
                       .ld(ld), .inc_word(inc_word), .sync_n(sync_n));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, lows = 0, ecnt = 0;
  int commit_at = -1, sync_at = -1;
  logic [7:0]  stage_m [4];
  logic [31:0] exp_word;
  logic        exp_sync = 1'b1, known = 1'b0, started = 1'b0, done = 1'b0;
  string       cur_req = "R6";

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, exp, ecnt);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    ecnt++;
    if (rst) started = 1'b1;
    if (ecnt == commit_at) begin
      exp_word = {stage_m[0], stage_m[1], stage_m[2], stage_m[3]};
      known = 1'b1;
    end
    exp_sync = (ecnt == sync_at) ? 1'b0 : 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      if (!sync_n) lows++;
      check(cur_req, {31'd0, sync_n}, {31'd0, exp_sync});
      if (known) check(cur_req, inc_word, exp_word);
    end
  end

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; wr_n = 1'b0;
    stage_m[a] = d;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input int hold);
    @(negedge clk);
    ld = 1'b1;
    commit_at = ecnt + 3;
    sync_at   = commit_at + 33;
    repeat (hold) @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; commit_at = -1; sync_at = -1;
    repeat (4) @(negedge clk);
    check("R6", {31'd0, sync_n}, 32'd1);
    rst = 1'b0;
    sync_at = ecnt + 1 + 34;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R6";
    do_reset();
    repeat (40) @(negedge clk);

    cur_req = "R1";
    wr_byte(2'b11, 8'h78);
    wr_byte(2'b10, 8'h56);
    wr_byte(2'b01, 8'h34);
    wr_byte(2'b00, 8'h12);
    cur_req = "R3";
    load(4);
    repeat (40) @(negedge clk);
    check("R1", inc_word, 32'h1234_5678);

    cur_req = "R2";
    wr_byte(2'b11, 8'h01);
    load(4);
    repeat (40) @(negedge clk);
    check("R2", inc_word, 32'h1234_5601);

    cur_req = "R4";
    wr_byte(2'b00, 8'hAB);
    repeat (20) @(negedge clk);
    check("R4", inc_word, 32'h1234_5601);
    cur_req = "R5";
    lows = 0;
    load(4);
    repeat (40) @(negedge clk);
    check("R5", inc_word, 32'hAB34_5601);
    check("R5", lows, 1);

    cur_req = "R8";
    lows = 0;
    load(4);
    wr_byte(2'b10, 8'hCD);
    load(4);
    repeat (45) @(negedge clk);
    check("R8", inc_word, 32'hAB34_CD01);
    check("R8", lows, 1);

    cur_req = "R7";
    lows = 0;
    do_reset();
    check("R7", inc_word, 32'hAB34_CD01);
    repeat (40) @(negedge clk);
    check("R6", lows, 1);

    cur_req = "R9";
    wr_byte(2'b01, 8'hE5);
    lows = 0;
    load(60);
    repeat (45) @(negedge clk);
    check("R9", inc_word, 32'hABE5_CD01);
    check("R9", lows, 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule